// File: doc/BRIEF.md
# Vertical Sync Cleaner with Field Detection

This block takes horizontal and vertical sync pulses and rebuilds the vertical sync so that it has a fixed place relative to the horizontal sync. Both sync inputs must already be active-high and synchronous to the pixel clock. The block times the line by counting clocks between horizontal leading edges. When a vertical leading edge arrives, it works out which quarter of the line the edge lands in. The quarters are measured from a reference point that sits a programmable number of clocks after the horizontal edge. An edge in the first or last quarter gives field 0. An edge in one of the two middle quarters gives field 1.

The cleaned pulse starts on the line after the one in which the input edge was seen. For field 0 it starts on that line's horizontal leading edge. For field 1 it starts half a line period later. Any vertical edge that comes too few lines after the last accepted one is dropped, which removes stray pulses. The output width is one of two things. By default it copies the clock width of the input pulse. When the duration stage is enabled, it lasts a programmed number of lines instead. When the filter is off, the input vertical sync goes straight to the output.

Top module: `vsync_field_filter`

## Requirements
- R1: While reset is asserted and after it is released, `field` is 0 and no rebuilt pulse is pending. With `filt_en` at 0, `vs_out` follows `vs_in`.
- R2: With the filter on, a vertical leading edge whose offset from the quarter reference falls in the first or last quarter of the measured line sets `field` to 0. `vs_out` then rises in the clock of the next line's horizontal leading edge.
- R3: A vertical leading edge in the second or third quarter sets `field` to 1. `vs_out` then rises `period/2` clocks after the next line's horizontal leading edge.
- R4: The quarter reference is the horizontal leading edge plus `sep_thr` clocks. An offset that would fall before the reference is wrapped by adding the measured period.
- R5: A vertical leading edge is accepted only if at least `MIN_GAP` (64) horizontal leading edges have passed since the last accepted one. An edge with 63 or fewer between is ignored and produces no output pulse.
- R6: With `filt_en` at 0, `vs_out` equals `vs_in` in the same cycle, and `field` holds its value.
- R7: With `dur_en` at 1, `vs_out` falls right after the Nth horizontal leading edge that follows the point where it rose, where N is `dur_lines`. A `dur_lines` of 0 acts as 1.
- R8: With `dur_en` at 0, `vs_out` stays high for exactly as many clocks as the accepted input pulse stayed high.
- R9: Until a full line period has been measured after reset, every accepted edge is treated as field 0 and aligned to the horizontal edge.
- R10: `field` changes only in the cycle in which a rebuilt pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync, active high |
| filt_en | input | 1 | Enables realignment and field detection |
| dur_en | input | 1 | Selects a programmed output width in lines |
| dur_lines | input | 8 | Output width in lines (0 acts as 1) |
| sep_thr | input | PW (12) | Quarter reference offset in clocks |
| vs_out | output | 1 | Rebuilt or passed-through vertical sync |
| field | output | 1 | Detected field |

## Verification
The assertions assume several things about the inputs:
- Each sync leading edge is a clean single-cycle transition from low to high.
- The line period is at least two clocks and fits in `PW` bits.
- `sep_thr` is smaller than the line period, so one wrap is enough.
- A programmed duration ends before the next edge can be accepted.

The stimulus stays inside these limits. Every line is a fixed 40 clocks, with a 4-clock horizontal pulse. Every offset stays below 40. Durations are at most three lines. Consecutive vertical pulses are at least 40 lines apart, and the frames are long enough to cover the whole 64-line spacing window.

// File: rtl/vsync_field_filter.sv
module vsync_field_filter #(
  parameter int PW      = 12,
  parameter int MIN_GAP = 64,
  parameter int WW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          filt_en,
  input  logic          dur_en,
  input  logic [7:0]    dur_lines,
  input  logic [PW-1:0] sep_thr,
  output logic          vs_out,
  output logic          field
);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(MIN_GAP);

  logic          hs_d, vs_d, hs_seen, per_ok;
  logic [PW-1:0] pos_q, per_q;
  logic [GW-1:0] gap_q;
  logic          pend_q, pend_f, mid_q, vs_q, field_q, meas_q;
  logic [WW-1:0] in_w, o_cnt;
  logic [7:0]    ln_q;

  wire hs_rise = hs_in & ~hs_d;
  wire vs_rise = vs_in & ~vs_d;
  wire [PW-1:0] pos  = hs_rise ? '0 : pos_q;
  wire [PW-1:0] half = per_q >> 1;

  wire [PW:0]   diff = {1'b0, pos} - {1'b0, sep_thr};
  wire [PW-1:0] rel  = diff[PW] ? diff[PW-1:0] + per_q : diff[PW-1:0];
  wire [PW+1:0] r4   = {rel, 2'b00};
  wire [PW+1:0] p1   = {2'b00, per_q};
  wire [PW+1:0] p3   = p1 + {1'b0, per_q, 1'b0};
  wire late_field    = per_ok && (r4 >= p1) && (r4 < p3);

  wire accept  = filt_en & vs_rise & (gap_q == GAP_FULL);
  wire launch0 = pend_q & ~pend_f & hs_rise;
  wire arm_mid = pend_q & pend_f & hs_rise;
  wire launch1 = mid_q & ~hs_rise & (pos == half);
  wire launch  = launch0 | launch1;
  wire [7:0] dmax = (dur_lines == 8'd0) ? 8'd1 : dur_lines;
  wire lines_done = ({1'b0, ln_q} + 9'd1) >= {1'b0, dmax};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d <= 1'b0; vs_d <= 1'b0; hs_seen <= 1'b0; per_ok <= 1'b0;
      pos_q <= '0; per_q <= '0; gap_q <= GAP_FULL;
      pend_q <= 1'b0; pend_f <= 1'b0; mid_q <= 1'b0;
      vs_q <= 1'b0; field_q <= 1'b0; meas_q <= 1'b0;
      in_w <= '0; o_cnt <= '0; ln_q <= '0;
    end else begin
      hs_d <= hs_in;
      vs_d <= vs_in;
      if (hs_rise) pos_q <= PW'(1);
      else if (pos_q != '1) pos_q <= pos_q + 1'b1;
      if (hs_rise) begin
        hs_seen <= 1'b1;
        if (hs_seen) begin
          per_q  <= pos_q;
          per_ok <= 1'b1;
        end
      end
      if (accept) gap_q <= '0;
      else if (hs_rise && gap_q != GAP_FULL) gap_q <= gap_q + 1'b1;

      if (accept) begin
        in_w   <= WW'(1);
        meas_q <= 1'b1;
      end else if (meas_q) begin
        if (!vs_in) meas_q <= 1'b0;
        else if (in_w != '1) in_w <= in_w + 1'b1;
      end

      if (!filt_en) begin
        pend_q <= 1'b0;
        mid_q  <= 1'b0;
        vs_q   <= 1'b0;
      end else begin
        if (accept) begin
          pend_q <= 1'b1;
          pend_f <= late_field;
        end else if (launch0 || arm_mid) pend_q <= 1'b0;
        if (arm_mid) mid_q <= 1'b1;
        else if (launch1) mid_q <= 1'b0;
        if (launch) begin
          vs_q    <= 1'b1;
          field_q <= launch1;
          o_cnt   <= WW'(1);
          ln_q    <= '0;
        end else if (vs_q) begin
          if (dur_en) begin
            if (hs_rise) begin
              if (lines_done) vs_q <= 1'b0;
              else ln_q <= ln_q + 1'b1;
            end
          end else if (o_cnt >= in_w && !meas_q) vs_q <= 1'b0;
          else o_cnt <= o_cnt + 1'b1;
        end
      end
    end
  end

  assign vs_out = filt_en ? vs_q : vs_in;
  assign field  = field_q;

  assert_field0_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_q) && !field_q |-> $past(hs_in && !hs_d));
  assert_field1_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_q) && field_q |-> $past(pos_q == half) && per_ok);
  assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(filt_en) |-> $stable(field_q));
  assert_dur_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_q) && $past(dur_en) && $past(filt_en) |-> $past(hs_in && !hs_d));
  assert_field_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_q) |-> vs_q);
endmodule

// File: tb/tb_vsync_field_filter.sv
module tb_vsync_field_filter;
  localparam int P = 40;
  localparam int HSW = 4;
  localparam int NV = 8;
  localparam int V_THR[NV] = '{0, 0, 0, 0, 8, 8, 8, 30};
  localparam int V_OFF[NV] = '{5, 15, 25, 35, 5, 12, 20, 5};
  localparam int V_W[NV]   = '{6, 3, 10, 6, 6, 6, 50, 6};
  localparam int V_DE[NV]  = '{0, 0, 1, 1, 0, 1, 0, 0};
  localparam int V_DL[NV]  = '{4, 4, 2, 0, 4, 3, 4, 4};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hs_in, vs_in, filt_en, dur_en, vs_out, field;
  logic [7:0] dur_lines;
  logic [11:0] sep_thr;

  vsync_field_filter dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .filt_en(filt_en),
    .dur_en(dur_en), .dur_lines(dur_lines), .sep_thr(sep_thr),
    .vs_out(vs_out), .field(field)
  );

  int errs = 0, checks = 0, g = 0;
  int nrise, rise_at, last_rise, width, fld_before;
  logic prev_vs, prev_fld;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit vs);
    @(negedge clk);
    if (vs_out && !prev_vs) begin
      nrise++;
      last_rise = g - 1;
      if (nrise == 1) begin
        rise_at = g - 1;
        fld_before = int'(prev_fld);
      end
    end
    if (vs_out) width++;
    prev_vs  = vs_out;
    prev_fld = field;
    hs_in = (g % P) < HSW;
    vs_in = vs;
    g++;
  endtask

  task automatic frame(input int nl, input int l1, input int o1, input int w,
                       input int l2, input int o2);
    nrise = 0; width = 0; rise_at = -1; last_rise = -1;
    for (int k = 0; k < nl * P; k++)
      step((k >= l1 * P + o1 && k < l1 * P + o1 + w) ||
           (l2 >= 0 && k >= l2 * P + o2 && k < l2 * P + o2 + w));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 20);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int base, f, rel, d, ew, pf;
    rst_n = 1'b0; hs_in = 1'b0; vs_in = 1'b0; filt_en = 1'b0;
    dur_en = 1'b0; dur_lines = 8'd4; sep_thr = '0;
    prev_vs = 1'b0; prev_fld = 1'b0;
    for (int k = 0; k < 2 * P; k++) step(1'b0);
    @(negedge clk);
    chk(field == 1'b0 && vs_out == 1'b0, "R1 reset", int'(field), 0);
    vs_in = 1'b1; #1;
    chk(vs_out == 1'b1, "R1 bypass after reset", int'(vs_out), 1);
    vs_in = 1'b0;
    rst_n = 1'b1; filt_en = 1'b1;

    base = g;
    frame(70, 0, 20, 6, -1, 0);
    chk(rise_at == base + P, "R9 unmeasured edge aligned", rise_at - base, P);
    chk(field == 1'b0, "R9 field", int'(field), 0);
    pf = 0;

    for (int i = 0; i < NV; i++) begin
      sep_thr = 12'(V_THR[i]); dur_en = V_DE[i][0]; dur_lines = 8'(V_DL[i]);
      rel = V_OFF[i] - V_THR[i];
      if (rel < 0) rel += P;
      f = ((4 * rel) / P == 1 || (4 * rel) / P == 2) ? 1 : 0;
      d = (V_DL[i] == 0) ? 1 : V_DL[i];
      ew = V_DE[i] ? (f ? d * P - P / 2 : d * P) : V_W[i];
      base = g;
      frame(70, 1, V_OFF[i], V_W[i], -1, 0);
      if (V_THR[i] != 0) begin
        chk(int'(field) == f, "R4 field with offset", int'(field), f);
        chk(rise_at == base + 2 * P + f * (P / 2), "R4 start", rise_at - base, 2 * P + f * (P / 2));
      end else if (f == 1) begin
        chk(field == 1'b1, "R3 field", int'(field), 1);
        chk(rise_at == base + 2 * P + P / 2, "R3 mid start", rise_at - base, 2 * P + P / 2);
      end else begin
        chk(field == 1'b0, "R2 field", int'(field), 0);
        chk(rise_at == base + 2 * P, "R2 edge start", rise_at - base, 2 * P);
      end
      if (V_DE[i] != 0) chk(width == ew, "R7 width in lines", width, ew);
      else chk(width == ew, "R8 width copies input", width, ew);
      chk(fld_before == pf, "R10 field before start", fld_before, pf);
      pf = f;
    end

    dur_en = 1'b0; sep_thr = '0;
    frame(70, 1, 5, 6, 41, 5);
    chk(nrise == 1, "R5 reject at 40 lines", nrise, 1);
    frame(140, 1, 5, 6, 64, 5);
    chk(nrise == 1, "R5 reject at 63 lines", nrise, 1);
    base = g;
    frame(140, 1, 5, 6, 65, 5);
    chk(nrise == 2, "R5 accept at 64 lines", nrise, 2);
    chk(last_rise == base + 66 * P, "R5 second start", last_rise - base, 66 * P);

    filt_en = 1'b0;
    pf = int'(field);
    base = g;
    frame(70, 1, 25, 7, -1, 0);
    chk(rise_at == base + P + 25, "R6 passthrough timing", rise_at - base, P + 25);
    chk(width == 7 && nrise == 1, "R6 passthrough width", width, 7);
    chk(int'(field) == pf, "R6 field held", int'(field), pf);
    finish_run();
  end
endmodule